// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address for a 32-bit MMU that has no address-extension mode. A caller pulses `start` with the address, the kind of access (read or write, user or supervisor) and the current control settings. When paging is on, the walker reads a directory entry and, for ordinary 4 KB pages, a table entry from memory. It checks the present and permission bits of each entry, writes back the accessed and dirty flags when they change, and then gives a one-cycle `done`. With `done` it reports either a physical address with its read, write and execute rights or a page fault with an error code.

Memory is reached through one 32-bit port that carries one read or one write per transaction. Each transaction is a request held until the memory returns a valid, with any number of wait states. Every table address goes through the A20 gate: when the gate is low, address bit 20 is forced to zero. A directory entry with its page-size bit set maps a 4 MB page, but only while large pages are enabled.

Top module: `ptw_walker`

## Requirements
- R1: With `pg_on` low at `start`, `done` rises in the next cycle with no memory access, `fault`=0, `phys_addr` = `lin_addr` with bit 20 cleared when `a20_gate` is low, all three rights set and `big_page`=0.
- R2: The first read goes to ((`dir_base` & ~0xFFF) + 4 × `lin_addr`[31:22]) AND the A20 mask. The mask is all ones, except that bit 20 is zero when `a20_gate` is low.
- R3: If bit 0 (present) of the directory entry or of the table entry is clear, the walk ends in a fault with `err_code`[0]=0.
- R4: If directory entry bit 7 and `pse_on` are both set, no table entry is read. The result is `phys_addr` = {entry[31:22], `lin_addr`[21:0]} with `big_page`=1, and the rights come from the directory entry alone. With `pse_on` low, bit 7 is ignored.
- R5: For a 4 KB page, the table entry address is ((directory entry & ~0xFFF) + 4 × `lin_addr`[21:12]) AND the A20 mask. `phys_addr` = ({entry[31:12], `lin_addr`[11:0]}) AND the mask. The user right (bit 2) and the write right (bit 1) are each the AND of both entries.
- R6: A user access faults if the user right is missing, or if it is a write without the write right. A supervisor write faults only when `wp_on` is set and the write right is missing. Such a protection fault has `err_code`[0]=1.
- R7: On any fault, `err_code`[1] equals the write flag and `err_code`[2] the user flag, and `fault_addr` takes the linear address. `fault_addr` is unchanged by a walk that succeeds.
- R8: In a 4 KB walk, a directory entry whose accessed bit (bit 5) is clear is written back with that bit set before the table entry is read. An entry whose accessed bit is already set is not written.
- R9: The final entry is written back with the accessed bit set, and on a write also with the dirty bit (bit 6) set, only if either bit changes. No final write-back happens on a fault.
- R10: `can_write` is 1 only if the final entry is dirty after the walk's own update and the rights allow a write: a user access needs the write right, a supervisor access needs the write right or `wp_on` low. `can_read` and `can_exec` are 1 on every successful walk.
- R11: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until a cycle in which `mem_valid` is high. Any number of wait states is accepted.
- R12: `done` is high for exactly one cycle per walk. A `start` that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| lin_addr | input | 32 | Linear address to translate |
| acc_write | input | 1 | Access is a write |
| acc_user | input | 1 | Access is from user level |
| pg_on | input | 1 | Paging enabled |
| wp_on | input | 1 | Supervisor write protection enabled |
| pse_on | input | 1 | 4 MB pages enabled |
| a20_gate | input | 1 | Low forces address bit 20 to zero |
| dir_base | input | 32 | Page directory base address |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Transaction address |
| mem_wdata | output | 32 | Write data |
| mem_valid | input | 1 | Transaction complete (read data valid) |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle walk completion |
| fault | output | 1 | Walk ended in a page fault |
| err_code | output | 3 | Fault code: bit 0 protection, bit 1 write, bit 2 user |
| fault_addr | output | 32 | Linear address of the last fault |
| phys_addr | output | 32 | Translated physical address |
| can_read | output | 1 | Read right granted |
| can_write | output | 1 | Write right granted |
| can_exec | output | 1 | Execute right granted |
| big_page | output | 1 | Translation used a 4 MB page |

## Verification
A wrong walk state shows up at the memory port within the same transaction. It appears as a read or write at an unexpected address, a write-back with wrong data, or an extra or missing access, and each of these is compared with the model the moment the memory completes it. A wrong latched entry or wrong rights logic shows up on the `done` cycle as a bad physical address, wrong rights or a wrong error code. A broken fault path also leaves `fault_addr` wrong for all later walks. Random wait states on the port expose any address or data that is not held while a request is pending.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int BIG_SHIFT  = 22;
    localparam int A20_BIT    = 20;
    localparam int IDX_W      = BIG_SHIFT - PAGE_SHIFT;

    // entry bit positions
    localparam int P_BIT  = 0;
    localparam int RW_BIT = 1;
    localparam int US_BIT = 2;
    localparam int A_BIT  = 5;
    localparam int D_BIT  = 6;
    localparam int PS_BIT = 7;

    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((1 << PAGE_SHIFT) - 1);
    localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'(((1 << IDX_W) - 1) << 2);

    typedef enum logic [2:0] {
        S_IDLE, S_RD_DIR, S_EV_DIR, S_WB_DIR,
        S_RD_TBL, S_EV_TBL, S_WB_TBL, S_FIN
    } walk_state_t;

    typedef struct packed {
        logic              fault;
        logic [2:0]        err;
        logic [ADDR_W-1:0] phys;
        logic              rd;
        logic              wr;
        logic              ex;
        logic              big;
    } walk_result_t;

    function automatic logic [ADDR_W-1:0] a20_mask(input logic gate);
        logic [ADDR_W-1:0] m;
        m = '1;
        m[A20_BIT] = gate;
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] dir_entry_addr(
        input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] lin,
        input logic [ADDR_W-1:0] mask);
        return ((base & ~OFS_MASK) + ((lin >> (BIG_SHIFT - 2)) & IDX_MASK)) & mask;
    endfunction

    function automatic logic [ADDR_W-1:0] tbl_entry_addr(
        input logic [ADDR_W-1:0] dent, input logic [ADDR_W-1:0] lin,
        input logic [ADDR_W-1:0] mask);
        return ((dent & ~OFS_MASK) + ((lin >> (PAGE_SHIFT - 2)) & IDX_MASK)) & mask;
    endfunction
endpackage

// File: rtl/ptw_perm.sv
module ptw_perm (
    input  logic rw_ok,
    input  logic us_ok,
    input  logic acc_user,
    input  logic acc_write,
    input  logic wp,
    input  logic dirty_after,
    output logic violate,
    output logic grant_w
);
    always_comb begin
        if (acc_user) begin
            violate = !us_ok || (acc_write && !rw_ok);
            grant_w = dirty_after && rw_ok;
        end else begin
            violate = wp && acc_write && !rw_ok;
            grant_w = dirty_after && (!wp || rw_ok);
        end
    end
endmodule

// File: rtl/ptw_upd.sv
module ptw_upd
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] entry,
    input  logic              acc_write,
    input  logic              is_leaf,
    output logic [ADDR_W-1:0] new_entry,
    output logic              need_wb,
    output logic              dirty_after
);
    logic set_d;

    always_comb begin
        set_d              = is_leaf && acc_write && !entry[D_BIT];
        new_entry          = entry;
        new_entry[A_BIT]   = 1'b1;
        if (set_d) new_entry[D_BIT] = 1'b1;
        need_wb            = !entry[A_BIT] || set_d;
        dirty_after        = entry[D_BIT] || set_d;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] lin_addr,
    input  logic              acc_write,
    input  logic              acc_user,
    input  logic              pg_on,
    input  logic              wp_on,
    input  logic              pse_on,
    input  logic              a20_gate,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [2:0]        err_code,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              can_read,
    output logic              can_write,
    output logic              can_exec,
    output logic              big_page
);
    walk_state_t       st;
    logic [ADDR_W-1:0] lin_q, mask_q, dent_q, tent_q, cr2_q;
    logic [ADDR_W-1:0] maddr_q, wdata_q;
    logic              wr_q, us_q, wp_q, pse_q, req_q, we_q;
    walk_result_t      res_q;

    logic              at_tbl, big, is_leaf, rw_eff, us_eff;
    logic              need_wb, dirty_after, violate, grant_w;
    logic [ADDR_W-1:0] cur, new_entry, tbl_addr, leaf_phys;
    walk_result_t      leaf_res;

    assign at_tbl   = (st == S_EV_TBL);
    assign big      = dent_q[PS_BIT] && pse_q;
    assign is_leaf  = at_tbl || big;
    assign cur      = at_tbl ? tent_q : dent_q;
    assign rw_eff   = at_tbl ? (dent_q[RW_BIT] && tent_q[RW_BIT]) : dent_q[RW_BIT];
    assign us_eff   = at_tbl ? (dent_q[US_BIT] && tent_q[US_BIT]) : dent_q[US_BIT];
    assign tbl_addr = tbl_entry_addr(dent_q, lin_q, mask_q);
    assign leaf_phys = big ? {dent_q[ADDR_W-1:BIG_SHIFT], lin_q[BIG_SHIFT-1:0]}
                           : ({tent_q[ADDR_W-1:PAGE_SHIFT], lin_q[PAGE_SHIFT-1:0]} & mask_q);
    assign leaf_res = '{fault: 1'b0, err: 3'b000, phys: leaf_phys,
                        rd: 1'b1, wr: grant_w, ex: 1'b1, big: big};

    ptw_upd u_upd (
        .entry(cur), .acc_write(wr_q), .is_leaf(is_leaf),
        .new_entry(new_entry), .need_wb(need_wb), .dirty_after(dirty_after)
    );

    ptw_perm u_perm (
        .rw_ok(rw_eff), .us_ok(us_eff), .acc_user(us_q), .acc_write(wr_q),
        .wp(wp_q), .dirty_after(dirty_after), .violate(violate), .grant_w(grant_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            lin_q   <= '0;  mask_q <= '1;  dent_q <= '0;  tent_q <= '0;
            cr2_q   <= '0;  maddr_q <= '0; wdata_q <= '0;
            wr_q    <= 1'b0; us_q <= 1'b0; wp_q <= 1'b0; pse_q <= 1'b0;
            req_q   <= 1'b0; we_q <= 1'b0;
            res_q   <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    lin_q  <= lin_addr;  wr_q <= acc_write; us_q <= acc_user;
                    wp_q   <= wp_on;     pse_q <= pse_on;
                    mask_q <= a20_mask(a20_gate);
                    if (!pg_on) begin
                        res_q <= '{fault: 1'b0, err: 3'b000,
                                   phys: lin_addr & a20_mask(a20_gate),
                                   rd: 1'b1, wr: 1'b1, ex: 1'b1, big: 1'b0};
                        st    <= S_FIN;
                    end else begin
                        req_q   <= 1'b1;
                        we_q    <= 1'b0;
                        maddr_q <= dir_entry_addr(dir_base, lin_addr, a20_mask(a20_gate));
                        st      <= S_RD_DIR;
                    end
                end
                S_RD_DIR: if (mem_valid) begin
                    dent_q <= mem_rdata;
                    req_q  <= 1'b0;
                    st     <= S_EV_DIR;
                end
                S_EV_DIR: begin
                    if (!dent_q[P_BIT] || (big && violate)) begin
                        res_q.fault <= 1'b1;
                        res_q.err   <= {us_q, wr_q, dent_q[P_BIT]};
                        cr2_q       <= lin_q;
                        st          <= S_FIN;
                    end else if (need_wb) begin
                        if (big) res_q <= leaf_res;
                        req_q   <= 1'b1;
                        we_q    <= 1'b1;
                        wdata_q <= new_entry;
                        st      <= S_WB_DIR;
                    end else if (big) begin
                        res_q <= leaf_res;
                        st    <= S_FIN;
                    end else begin
                        req_q   <= 1'b1;
                        we_q    <= 1'b0;
                        maddr_q <= tbl_addr;
                        st      <= S_RD_TBL;
                    end
                end
                S_WB_DIR: if (mem_valid) begin
                    we_q <= 1'b0;
                    if (big) begin
                        req_q <= 1'b0;
                        st    <= S_FIN;
                    end else begin
                        maddr_q <= tbl_addr;
                        st      <= S_RD_TBL;
                    end
                end
                S_RD_TBL: if (mem_valid) begin
                    tent_q <= mem_rdata;
                    req_q  <= 1'b0;
                    st     <= S_EV_TBL;
                end
                S_EV_TBL: begin
                    if (!tent_q[P_BIT] || violate) begin
                        res_q.fault <= 1'b1;
                        res_q.err   <= {us_q, wr_q, tent_q[P_BIT]};
                        cr2_q       <= lin_q;
                        st          <= S_FIN;
                    end else begin
                        res_q <= leaf_res;
                        if (need_wb) begin
                            req_q   <= 1'b1;
                            we_q    <= 1'b1;
                            wdata_q <= new_entry;
                            st      <= S_WB_TBL;
                        end else begin
                            st <= S_FIN;
                        end
                    end
                end
                S_WB_TBL: if (mem_valid) begin
                    req_q <= 1'b0;
                    we_q  <= 1'b0;
                    st    <= S_FIN;
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign mem_req    = req_q;
    assign mem_we     = we_q;
    assign mem_addr   = maddr_q;
    assign mem_wdata  = wdata_q;
    assign done       = (st == S_FIN);
    assign fault      = res_q.fault;
    assign err_code   = res_q.err;
    assign fault_addr = cr2_q;
    assign phys_addr  = res_q.phys;
    assign can_read   = res_q.rd;
    assign can_write  = res_q.wr;
    assign can_exec   = res_q.ex;
    assign big_page   = res_q.big;

    // R11: a pending request keeps its address, direction and data
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R12: completion lasts a single cycle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: a new fault only appears together with completion
    a_r7_fault_at_done: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> done);

    // R7: the fault address changes only on a faulting completion
    a_r7_cr2_only_on_fault: assert property (@(posedge clk) disable iff (rst)
        !$stable(fault_addr) |-> done && fault);

    // R2: every table access respects the A20 gate
    a_r2_a20_masked: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mask_q[A20_BIT] |-> !mem_addr[A20_BIT]);

    // R9: every write-back carries a set accessed bit
    a_r9_wb_accessed: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_wdata[A_BIT]);
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] lin_addr = '0;
    logic        acc_write = 1'b0, acc_user = 1'b0;
    logic        pg_on = 1'b0, wp_on = 1'b0, pse_on = 1'b0, a20_gate = 1'b1;
    logic [31:0] dir_base = 32'h0000_1000;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, fault, can_read, can_write, can_exec, big_page;
    logic [2:0]  err_code;
    logic [31:0] fault_addr, phys_addr;

    ptw_walker dut (
        .clk(clk), .rst(rst), .start(start), .lin_addr(lin_addr),
        .acc_write(acc_write), .acc_user(acc_user), .pg_on(pg_on),
        .wp_on(wp_on), .pse_on(pse_on), .a20_gate(a20_gate), .dir_base(dir_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .err_code(err_code), .fault_addr(fault_addr),
        .phys_addr(phys_addr), .can_read(can_read), .can_write(can_write),
        .can_exec(can_exec), .big_page(big_page)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } op_t;

    op_t         exp_ops[$];
    logic [31:0] mem [logic [31:0]];
    int          compared = 0, mismatched = 0;
    int          wait_cnt = 0, wait_len = 1;
    int unsigned lcg = 32'h1234_5678;
    logic        e_fault, e_w, e_big;
    logic [2:0]  e_err;
    logic [31:0] e_phys, e_cr2 = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // memory responder with varying wait states (R11)
    always @(negedge clk) begin
        if (rst) begin
            mem_valid = 1'b0;
            wait_cnt  = 0;
        end else if (mem_valid) begin
            mem_valid = 1'b0;
            wait_cnt  = 0;
        end else if (mem_req) begin
            if (wait_cnt >= wait_len) begin
                if (exp_ops.size() == 0) begin
                    check("R11 unexpected access", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    op_t o;
                    o = exp_ops.pop_front();
                    check({o.tag, " direction"}, {31'b0, mem_we}, {31'b0, o.we});
                    check({o.tag, " address"}, mem_addr, o.addr);
                    if (o.we) check({o.tag, " write data"}, mem_wdata, o.data);
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
                else        mem_rdata     = rd(mem_addr);
                mem_valid = 1'b1;
                lcg       = lcg * 1103515245 + 12345;
                wait_len  = int'((lcg >> 8) % 4);
                wait_cnt  = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    // behavioural reference of one walk, from the requirements
    task automatic model(input logic [31:0] lin, input logic w, input logic u);
        logic [31:0] msk, da, ta, pde, pte, ent, ent_addr, nent;
        logic        bigp, rw, us, viol;
        op_t         o;
        exp_ops.delete();
        e_big = 1'b0; e_w = 1'b0; e_phys = '0; e_err = '0; e_fault = 1'b0;
        msk = a20_gate ? 32'hFFFF_FFFF : 32'hFFEF_FFFF;
        if (!pg_on) begin
            e_phys = lin & msk; e_w = 1'b1;
            return;
        end
        da = ((dir_base & 32'hFFFF_F000) + 32'(lin[31:22]) * 4) & msk;
        o = '{we: 1'b0, addr: da, data: 32'h0, tag: "R2 dir read"};
        exp_ops.push_back(o);
        pde = rd(da);
        if (!pde[0]) begin
            e_fault = 1'b1; e_err = {u, w, 1'b0}; e_cr2 = lin;
            return;
        end
        bigp = pde[7] && pse_on;
        if (bigp) begin
            rw = pde[1]; us = pde[2]; ent = pde; ent_addr = da;
        end else begin
            if (!pde[5]) begin
                o = '{we: 1'b1, addr: da, data: pde | 32'h20, tag: "R8 dir accessed"};
                exp_ops.push_back(o);
            end
            ta = ((pde & 32'hFFFF_F000) + 32'(lin[21:12]) * 4) & msk;
            o = '{we: 1'b0, addr: ta, data: 32'h0, tag: "R5 table read"};
            exp_ops.push_back(o);
            pte = rd(ta);
            if (!pte[0]) begin
                e_fault = 1'b1; e_err = {u, w, 1'b0}; e_cr2 = lin;
                return;
            end
            rw = pde[1] & pte[1]; us = pde[2] & pte[2]; ent = pte; ent_addr = ta;
        end
        viol = u ? (!us || (w && !rw)) : (wp_on && w && !rw);
        if (viol) begin
            e_fault = 1'b1; e_err = {u, w, 1'b1}; e_cr2 = lin;
            return;
        end
        nent = ent | 32'h20 | (w ? 32'h40 : 32'h0);
        if (nent != ent) begin
            o = '{we: 1'b1, addr: ent_addr, data: nent, tag: "R9 final update"};
            exp_ops.push_back(o);
        end
        e_w   = nent[6] && (u ? rw : (!wp_on || rw));
        e_big = bigp;
        e_phys = bigp ? {pde[31:22], lin[21:0]} : ({ent[31:12], lin[11:0]} & msk);
    endtask

    task automatic run(input string name, input logic [31:0] lin, input logic w,
                       input logic u, input bit busy_poke);
        int k;
        bit seen;
        logic [31:0] keep_lin;
        logic        keep_pg;
        model(lin, w, u);
        keep_lin = lin; keep_pg = pg_on;
        lin_addr = lin; acc_write = w; acc_user = u; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (k = 0; k < 400; k++) begin
            if (done) begin seen = 1'b1; break; end
            if (busy_poke && k == 1) begin
                start = 1'b1; lin_addr = 32'hDEAD_B000; pg_on = 1'b0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; lin_addr = keep_lin; pg_on = keep_pg;
        check({name, " R12 done reached"}, {31'b0, seen}, 32'd1);
        if (!pg_on) check({name, " R1 done latency"}, k, 0);
        check({name, " R3 R6 fault"}, {31'b0, fault}, {31'b0, e_fault});
        check({name, " R7 fault address"}, fault_addr, e_cr2);
        if (e_fault) begin
            check({name, " R7 error code"}, {29'b0, err_code}, {29'b0, e_err});
        end else begin
            check({name, " R4 R5 physical"}, phys_addr, e_phys);
            check({name, " R10 rights"}, {29'b0, can_read, can_write, can_exec},
                  {29'b0, 1'b1, e_w, 1'b1});
            check({name, " R4 large flag"}, {31'b0, big_page}, {31'b0, e_big});
        end
        check({name, " R9 all accesses made"}, exp_ops.size(), 0);
        @(negedge clk);
        check({name, " R12 single-cycle done"}, {31'b0, done}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset done", {31'b0, done}, 32'd0);
        check("R11 reset request", {31'b0, mem_req}, 32'd0);
        check("R7 reset fault address", fault_addr, 32'd0);

        // R1: paging off, with and without A20
        pg_on = 1'b0; a20_gate = 1'b1;
        run("R1 unpaged", 32'h0012_3456, 1'b1, 1'b1, 1'b0);
        a20_gate = 1'b0;
        run("R1 unpaged a20", 32'h0017_8ABC, 1'b0, 1'b0, 1'b0);
        a20_gate = 1'b1; pg_on = 1'b1; dir_base = 32'h0000_1000;

        // R2 R5 R8 R9: fresh entries, user read
        mem[32'h0000_1004] = 32'h0000_2007;
        mem[32'h0000_2014] = 32'h0008_9007;
        run("R8 user read fresh", 32'h0040_5123, 1'b0, 1'b1, 1'b0);
        // R9 R10: same page written, dirty now set
        run("R10 user write", 32'h0040_5123, 1'b1, 1'b1, 1'b0);

        // R10: clean-state supervisor reads of a dirty read-only page
        mem[32'h0000_1008] = 32'h0000_3025;
        mem[32'h0000_301C] = 32'h000A_A065;
        wp_on = 1'b0;
        run("R10 sup read wp0", 32'h0080_7ABC, 1'b0, 1'b0, 1'b0);
        wp_on = 1'b1;
        run("R10 sup read wp1", 32'h0080_7ABC, 1'b0, 1'b0, 1'b0);
        // R6: supervisor write to read-only with WP set faults
        run("R6 sup write wp1", 32'h0080_7ABC, 1'b1, 1'b0, 1'b0);
        wp_on = 1'b0;
        run("R6 sup write wp0", 32'h0080_7ABC, 1'b1, 1'b0, 1'b0);
        // R6: user write to read-only page
        run("R6 user write ro", 32'h0080_7ABC, 1'b1, 1'b1, 1'b0);

        // R5 R6: user right removed by the table entry
        mem[32'h0000_100C] = 32'h0000_4027;
        mem[32'h0000_4004] = 32'h000B_B023;
        run("R5 user and", 32'h00C0_1000, 1'b0, 1'b1, 1'b0);

        // R3: directory entry not present
        mem[32'h0000_1010] = 32'h0000_0000;
        run("R3 dir absent", 32'h0100_0000, 1'b1, 1'b1, 1'b0);
        // R3 R8: table entry absent after directory write-back
        mem[32'h0000_1014] = 32'h0000_5003;
        mem[32'h0000_5008] = 32'h0000_0000;
        run("R3 table absent", 32'h0140_2000, 1'b0, 1'b0, 1'b0);

        // R4: large page, then the same entry with large pages disabled
        mem[32'h0000_1018] = 32'h0C00_0087;
        pse_on = 1'b1;
        run("R4 large write", 32'h0183_4567, 1'b1, 1'b0, 1'b0);
        pse_on = 1'b0;
        mem[32'h0C00_00D0] = 32'h0D00_0067;
        run("R4 pse off", 32'h0183_4567, 1'b0, 1'b0, 1'b0);

        // R2: A20 gate low while paging
        a20_gate = 1'b0; dir_base = 32'h0010_1000;
        mem[32'h0000_101C] = 32'h0016_0007;
        mem[32'h0006_0000] = 32'h0017_0067;
        run("R2 a20 walk", 32'h01C0_0234, 1'b0, 1'b1, 1'b0);
        a20_gate = 1'b1; dir_base = 32'h0000_1000;

        // R12: start while busy is ignored
        mem[32'h0000_1020] = 32'h0000_6007;
        mem[32'h0000_6000] = 32'h0009_9007;
        run("R12 busy start", 32'h0200_0010, 1'b0, 1'b1, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule